// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns for a fetch unit. Each call strobe places the address that follows the calling instruction on a small hardware stack. Each return strobe takes the most recent address off the stack. In the same cycle, the block presents that address as the predicted return target, together with a valid flag. Instructions are a fixed four bytes long, and addresses are 32 bits wide.

The stack depth is a parameter, with a default of four. A second parameter sets what happens when a call arrives and the stack is already full:
- **Circular policy:** the stack acts as a ring and overwrites the oldest entry.
- **Drop policy:** the call is ignored and the contents stay as they are.

An occupancy counter saturates at zero and at the depth, so full and empty stacks behave deterministically. If a call and a return arrive in the same cycle, the top entry is swapped for the new return address.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty: a return strobe yields `pred_valid_o`=0 and `pred_addr_o`=0.
- R2: A call at address P stores P+4, computed modulo 2^32. For example, a call at 0xFC34 stores 0xFC38, and a call at 0xFFFFFFFC stores 0x00000000.
- R3: A return on a non-empty stack raises `pred_valid_o` in the same cycle as `ret_i`, with `pred_addr_o` equal to the most recently stored entry. Successive returns give entries in last-in first-out order.
- R4: A return on an empty stack gives `pred_valid_o`=0 and `pred_addr_o`=0, and leaves all state unchanged.
- R5: With the circular policy (`POLICY`=0), a call on a full stack overwrites the oldest entry. The next DEPTH returns give the newest DEPTH entries, newest first, and the return after them finds the stack empty.
- R6: With the drop policy (`POLICY`=1), a call on a full stack is discarded. The next DEPTH returns give the entries that were present before that call.
- R7: A call and a return in the same cycle on a non-empty stack behave as follows:
  - The prediction is the current top entry.
  - That entry is then replaced by the call address plus 4.
  - Occupancy does not change.
- R8: A call and a return in the same cycle on an empty stack give `pred_valid_o`=0 and store the call address plus 4 as a normal push.
- R9: `pred_valid_o` is high only in a cycle where `ret_i` is high, and `pred_addr_o` is 0 whenever `pred_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| call_i | input | 1 | A call instruction is being predicted this cycle |
| call_pc_i | input | AW | Address of the call instruction |
| ret_i | input | 1 | A return instruction is being predicted this cycle |
| pred_addr_o | output | AW | Predicted return target, 0 when not valid |
| pred_valid_o | output | 1 | Prediction valid; high only with a return strobe on a non-empty stack |

## Verification
Two kinds of internal error show up at the ports in different ways:
- **Stray top pointer:** this surfaces on the very next return strobe as a wrong address.
- **Occupancy counter that misses a saturation limit:** this stays hidden until the stack is drained. It then shows as a valid prediction where an empty stack was expected, or as a missing prediction.

For that reason, each overflow and underflow scenario is followed by returns up to and past the depth. Both policies are run side by side on the same stimulus. A mistake in either variant's full-stack handling therefore appears within DEPTH+1 returns of the overflowing call.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    RAS_OVF_WRAP = 1'b0,
    RAS_OVF_DROP = 1'b1
  } ras_ovf_e;
endpackage

// File: rtl/ras_ctrl.sv
// Pointer and occupancy control for the return address stack.
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int       DEPTH  = 4,
  parameter ras_ovf_e POLICY = RAS_OVF_WRAP,
  localparam int      PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int      CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          we_o,
  output logic [PW-1:0] widx_o,
  output logic [PW-1:0] top_o,
  output logic [CW-1:0] occ_o,
  output logic          empty_o
);
  logic [PW-1:0] top_q, top_d, top_inc, top_dec;
  logic [CW-1:0] occ_q, occ_d;
  logic          full, empty, upd_en, wrap_full;

  assign full    = (occ_q == CW'(DEPTH));
  assign empty   = (occ_q == '0);
  assign top_inc = (top_q == PW'(DEPTH - 1)) ? '0 : top_q + 1'b1;
  assign top_dec = (top_q == '0) ? PW'(DEPTH - 1) : top_q - 1'b1;
  assign upd_en  = call_i | ret_i;

  generate
    if (POLICY == RAS_OVF_WRAP) begin : g_wrap
      assign wrap_full = 1'b1;
    end else begin : g_drop
      assign wrap_full = 1'b0;
    end
  endgenerate

  always_comb begin
    top_d  = top_q;
    occ_d  = occ_q;
    we_o   = 1'b0;
    widx_o = top_inc;
    if (call_i && ret_i && !empty) begin
      we_o   = 1'b1;
      widx_o = top_q;
    end else if (ret_i && !call_i) begin
      if (!empty) begin
        top_d = top_dec;
        occ_d = occ_q - 1'b1;
      end
    end else if (call_i) begin
      if (!full) begin
        we_o  = 1'b1;
        top_d = top_inc;
        occ_d = occ_q + 1'b1;
      end else if (wrap_full) begin
        we_o  = 1'b1;
        top_d = top_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      occ_q <= '0;
    end else if (upd_en) begin
      top_q <= top_d;
      occ_q <= occ_d;
    end
  end

  assign top_o   = top_q;
  assign occ_o   = occ_q;
  assign empty_o = empty;
endmodule

// File: rtl/ras_store.sv
// Entry array: one write port, one combinational read port.
module ras_store #(
  parameter int  DEPTH = 4,
  parameter int  AW    = 32,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [PW-1:0] widx_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [PW-1:0] ridx_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] ent_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (we_i && (widx_i == PW'(g))) begin
          ent_q[g] <= wdata_i;
        end
      end
    end
  endgenerate

  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/ras_predictor.sv
// Return address stack: top level.
module ras_predictor
  import ras_pkg::*;
#(
  parameter int       DEPTH      = 4,
  parameter int       AW         = 32,
  parameter int       INSN_BYTES = 4,
  parameter ras_ovf_e POLICY     = RAS_OVF_WRAP,
  localparam int      PW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int      CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic [AW-1:0] call_pc_i,
  input  logic          ret_i,
  output logic [AW-1:0] pred_addr_o,
  output logic          pred_valid_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic          we;
  logic [PW-1:0] widx, top;
  logic [CW-1:0] occ;
  logic          empty;
  logic [AW-1:0] link_addr, top_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign link_addr = call_pc_i + AW'(INSN_BYTES);

  ras_ctrl #(.DEPTH(DEPTH), .POLICY(POLICY)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .we_o    (we),
    .widx_o  (widx),
    .top_o   (top),
    .occ_o   (occ),
    .empty_o (empty)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk     (clk),
    .we_i    (we),
    .widx_i  (widx),
    .wdata_i (link_addr),
    .ridx_i  (top),
    .rdata_o (top_addr)
  );

  assign pred_valid_o = ret_i & ~empty;
  assign pred_addr_o  = pred_valid_o ? top_addr : '0;
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk
  import ras_pkg::*;
#(
  parameter int       DEPTH      = 4,
  parameter int       AW         = 32,
  parameter int       INSN_BYTES = 4,
  parameter ras_ovf_e POLICY     = RAS_OVF_WRAP,
  localparam int      CW         = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic [AW-1:0] call_pc_i,
  input logic          ret_i,
  input logic [AW-1:0] pred_addr_o,
  input logic          pred_valid_o,
  input logic [CW-1:0] occ
);
  localparam logic WRAPS = (POLICY == RAS_OVF_WRAP);

  AST_VALID_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o |-> ret_i);  // R9
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid_o |-> (pred_addr_o == '0));  // R9
  AST_EMPTY_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && occ == '0) |-> !pred_valid_o);  // R4
  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && occ == '0) |=> (occ == '0));  // R4
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));  // R5
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && occ == CW'(DEPTH)) |=> (occ == CW'(DEPTH)));  // R6
  AST_SWAP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && occ != '0) |=> $stable(occ));  // R7
  AST_PUSH_THEN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && (WRAPS || occ != CW'(DEPTH))) ##1 (ret_i && !call_i)
    |-> (pred_valid_o && pred_addr_o == $past(call_pc_i) + AW'(INSN_BYTES)));  // R2
endmodule

bind ras_predictor ras_predictor_chk #(
  .DEPTH(DEPTH), .AW(AW), .INSN_BYTES(INSN_BYTES), .POLICY(POLICY)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .call_i       (call_i),
  .call_pc_i    (call_pc_i),
  .ret_i        (ret_i),
  .pred_addr_o  (pred_addr_o),
  .pred_valid_o (pred_valid_o),
  .occ          (occ)
);

// File: tb/ras_predictor_tb_top.sv
module ras_predictor_tb_top;
  import ras_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  typedef struct {
    logic        v;
    logic [31:0] a;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i;
  logic [31:0] call_pc_i;
  logic        ret_i;
  logic [31:0] addr_w, addr_h;
  logic        valid_w, valid_h;

  exp_t        exp_w[$];
  exp_t        exp_h[$];
  logic [31:0] mdl_w[$];
  logic [31:0] mdl_h[$];
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ras_predictor #(.DEPTH(DEPTH), .POLICY(RAS_OVF_WRAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .pred_addr_o(addr_w), .pred_valid_o(valid_w)
  );

  ras_predictor #(.DEPTH(DEPTH), .POLICY(RAS_OVF_DROP)) dut_hold_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .pred_addr_o(addr_h), .pred_valid_o(valid_h)
  );

  // Reference stack from the requirements: expectation plus state update.
  task automatic model_step(ref logic [31:0] m[$], input bit wrap,
                            input logic c, input logic [31:0] pc,
                            input logic r, input string tag, output exp_t e);
    e.tag = tag;
    e.v   = r && (m.size() > 0);
    e.a   = e.v ? m[m.size() - 1] : 32'h0;
    if (c && r && m.size() > 0) begin
      m[m.size() - 1] = pc + 32'd4;
    end else if (r && !c) begin
      if (m.size() > 0) void'(m.pop_back());
    end else if (c) begin
      if (m.size() < DEPTH) m.push_back(pc + 32'd4);
      else if (wrap) begin
        void'(m.pop_front());
        m.push_back(pc + 32'd4);
      end
    end
  endtask

  task automatic op(input logic c, input logic [31:0] pc, input logic r,
                    input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    call_i    = c;
    call_pc_i = pc;
    ret_i     = r;
    model_step(mdl_w, 1'b1, c, pc, r, {tag, "/wrap"}, e);
    exp_w.push_back(e);
    model_step(mdl_h, 1'b0, c, pc, r, {tag, "/drop"}, e);
    exp_h.push_back(e);
  endtask

  // Monitor: compare mid-cycle against the scoreboard.
  always @(negedge clk) begin
    exp_t e;
    if (exp_w.size() > 0) begin
      e = exp_w.pop_front();
      checks++;
      if (valid_w !== e.v || addr_w !== e.a) begin
        errors++;
        $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                 e.tag, valid_w, addr_w, e.v, e.a);
      end
    end
    if (exp_h.size() > 0) begin
      e = exp_h.pop_front();
      checks++;
      if (valid_h !== e.v || addr_h !== e.a) begin
        errors++;
        $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                 e.tag, valid_h, addr_h, e.v, e.a);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    call_i = 1'b0; call_pc_i = '0; ret_i = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    op(0, 0, 1, "R1 reset empty");
    op(1, 32'h0000FC34, 0, "R2 push");
    op(0, 0, 0, "R9 idle no pred");
    op(0, 0, 1, "R2 R3 pop FC38");
    op(1, 32'h100, 0, "R3 push");
    op(1, 32'h200, 0, "R3 push");
    op(1, 32'h300, 0, "R3 push");
    op(0, 0, 1, "R3 lifo 1");
    op(0, 0, 1, "R3 lifo 2");
    op(0, 0, 1, "R3 lifo 3");
    op(0, 0, 1, "R4 empty pop");
    op(0, 0, 1, "R4 empty pop again");
    op(1, 32'h400, 0, "R4 push after empty");
    op(0, 0, 1, "R4 state intact");
    op(0, 0, 1, "R4 empty");
    for (int i = 1; i <= DEPTH + 2; i++) op(1, 32'h1000 * i, 0, "R5 R6 fill");
    for (int i = 0; i <= DEPTH; i++) op(0, 0, 1, "R5 R6 drain");
    op(1, 32'hA000, 0, "R7 push");
    op(1, 32'hB000, 0, "R7 push");
    op(1, 32'hC000, 1, "R7 swap");
    op(0, 0, 1, "R7 replaced top");
    op(0, 0, 1, "R7 below kept");
    op(0, 0, 1, "R7 occupancy same");
    op(1, 32'hD000, 1, "R8 swap on empty");
    op(0, 0, 1, "R8 pushed");
    op(0, 0, 1, "R8 then empty");
    op(1, 32'hFFFFFFFC, 0, "R2 pc wrap push");
    op(0, 0, 1, "R2 pc wrap pop");
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(lf[0], {lf, lf} & 32'hFFFFFFFC, lf[1] | lf[2], "R3 R5 R6 R7 R9 mix");
    end
    op(0, 0, 0, "R9 final idle");
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule